// File: doc/BRIEF.md
# Three-Sample Block Summer

This block receives a stream of 10-bit converter samples. Each sample is marked by a one-cycle enable strobe. It collects the samples into back-to-back groups of three that never share a sample (first, second and third make one group; fourth, fifth and sixth make the next). For each finished group it presents the total on a 12-bit output and raises a valid flag for one clock.

Only the first two samples of a group are kept, in a short shift buffer. The third sample is added straight from the input on the edge where it arrives. A position counter, cleared by reset, keeps the grouping aligned. Enable gaps may occur anywhere, including in the middle of a group, and they do not disturb the grouping. Between pulses the total keeps its last value, so a consumer can read it at any time after a pulse.

Top module: `tri_sample_summer`

## Requirements
- R1: A sample is taken only on a rising clock edge where `smp_en` is 1. Data present while `smp_en` is 0 never affects any later total.
- R2: Samples are grouped in arrival order into disjoint triples. The k-th total is the sum of enabled samples 3k-2, 3k-1 and 3k, counted from reset.
- R3: `sum_o` is 12 bits wide and holds the exact sum of three 10-bit values without wrapping. Three samples of 1023 give 3069.
- R4: `sum_vld` is 1 for exactly one clock: the cycle after the edge that took the third sample of a group. It is 0 in every other cycle.
- R5: No total is produced before three samples have been taken after reset. The first two enabled samples leave `sum_vld` at 0.
- R6: While `rst_n` is 0, `sum_vld` and `sum_o` read 0 and the group position returns to the start of a group.
- R7: `sum_o` keeps its value in every cycle in which `sum_vld` is 0.
- R8: A reset in the middle of a group discards the samples already taken. The first total after reset covers only the three samples taken after it.
- R9: Cycles with `smp_en` at 0 inside a group neither close the group nor shift the grouping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_en | input | 1 | Marks `smp_data` as a sample on this edge |
| smp_data | input | 10 | Unsigned sample value |
| sum_o | output | 12 | Total of the most recent finished group |
| sum_vld | output | 1 | One-clock pulse after a group closes |

## Verification
The bench uses the default build: 10-bit samples and groups of three. This keeps the whole sample range within reach. A sweep feeds every value from 0 to 1023 through the summer, with enable gaps placed inside groups. A second run drives full-scale samples to reach the largest possible total. Reset is also applied with a group half filled. The bench models the totals arithmetically and compares both outputs in every cycle.

// File: rtl/tsum_pkg.sv
package tsum_pkg;

    localparam int unsigned TSUM_SAMPLE_W = 10;
    localparam int unsigned TSUM_GROUP_N  = 3;

    // Bits needed to hold the sum of n values of w bits each without wrap.
    function automatic int unsigned tsum_sum_width(input int unsigned w, input int unsigned n);
        return w + $clog2(n);
    endfunction

endpackage

// File: rtl/tsum_phase.sv
// Tracks the position of the next sample inside its group.
module tsum_phase #(
    parameter int unsigned GROUP_N = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         smp_en,
    output logic [$clog2(GROUP_N)-1:0]   pos_o,
    output logic                         close_o
);
    localparam int unsigned POS_W = $clog2(GROUP_N);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(GROUP_N - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } phase_st_t;

    phase_st_t st_d, st_q;
    logic      at_last;

    always_comb begin
        st_d    = st_q;
        at_last = (st_q.pos == POS_LAST);
        if (smp_en) begin
            if (at_last) begin
                st_d.pos = '0;
            end else begin
                st_d.pos = st_q.pos + POS_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_o   = st_q.pos;
    assign close_o = smp_en && at_last;

endmodule

// File: rtl/tsum_history.sv
// Shift buffer holding the leading samples of the open group.
module tsum_history #(
    parameter int unsigned SAMPLE_W = 10,
    parameter int unsigned DEPTH    = 2,
    parameter int unsigned SUM_W    = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic [SAMPLE_W-1:0] din,
    output logic [SUM_W-1:0]    partial_o
);
    typedef struct packed {
        logic [DEPTH-1:0][SAMPLE_W-1:0] slot;
    } hist_st_t;

    hist_st_t st_d, st_q;
    logic [SUM_W-1:0] wide [DEPTH];

    // Zero-extend each stored slot to the sum width.
    for (genvar g = 0; g < DEPTH; g++) begin : g_widen
        assign wide[g] = SUM_W'(st_q.slot[g]);
    end

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.slot[0] = din;
            for (int k = 1; k < DEPTH; k++) begin
                st_d.slot[k] = st_q.slot[k-1];
            end
        end
    end

    always_comb begin
        partial_o = '0;
        for (int k = 0; k < DEPTH; k++) begin
            partial_o = partial_o + wide[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tsum_accum.sv
// Output stage: registers the group total and the one-clock valid pulse.
module tsum_accum #(
    parameter int unsigned SAMPLE_W = 10,
    parameter int unsigned SUM_W    = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                close_i,
    input  logic [SUM_W-1:0]    partial_i,
    input  logic [SAMPLE_W-1:0] din,
    output logic [SUM_W-1:0]    sum_o,
    output logic                vld_o
);
    typedef struct packed {
        logic [SUM_W-1:0] sum;
        logic             vld;
    } acc_st_t;

    acc_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = close_i;
        if (close_i) begin
            st_d.sum = partial_i + SUM_W'(din);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum_o = st_q.sum;
    assign vld_o = st_q.vld;

endmodule

// File: rtl/tri_sample_summer.sv
module tri_sample_summer
    import tsum_pkg::*;
#(
    parameter int unsigned SAMPLE_W = TSUM_SAMPLE_W,
    parameter int unsigned GROUP_N  = TSUM_GROUP_N,
    localparam int unsigned SUM_W   = tsum_sum_width(SAMPLE_W, GROUP_N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_en,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic [SUM_W-1:0]    sum_o,
    output logic                sum_vld
);
    localparam int unsigned POS_W = $clog2(GROUP_N);
    localparam int unsigned DEPTH = GROUP_N - 1;

    logic [POS_W-1:0] pos;
    logic             close;
    logic             shift_en;
    logic [SUM_W-1:0] partial;

    tsum_phase #(.GROUP_N(GROUP_N)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_en  (smp_en),
        .pos_o   (pos),
        .close_o (close)
    );

    // The closing sample goes straight into the total and is never stored.
    assign shift_en = smp_en && !close;

    tsum_history #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH), .SUM_W(SUM_W)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .din       (smp_data),
        .partial_o (partial)
    );

    tsum_accum #(.SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .close_i   (close),
        .partial_i (partial),
        .din       (smp_data),
        .sum_o     (sum_o),
        .vld_o     (sum_vld)
    );

    logic unused_pos;
    assign unused_pos = ^pos;

endmodule

// File: rtl/tsum_checker.sv
module tsum_checker #(
    parameter int unsigned SAMPLE_W = 10,
    parameter int unsigned GROUP_N  = 3,
    parameter int unsigned SUM_W    = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_en,
    input logic [SUM_W-1:0] sum_o,
    input logic             sum_vld
);
    localparam int unsigned CW = $clog2(GROUP_N);
    localparam logic [SUM_W-1:0] SUM_MAX = SUM_W'(GROUP_N * ((1 << SAMPLE_W) - 1));

    logic [CW-1:0] cnt_q;
    logic [CW:0]   seen_q;
    logic          exp_vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            seen_q    <= '0;
            exp_vld_q <= 1'b0;
        end else begin
            exp_vld_q <= smp_en && (cnt_q == CW'(GROUP_N - 1));
            if (smp_en) begin
                cnt_q <= (cnt_q == CW'(GROUP_N - 1)) ? '0 : cnt_q + CW'(1);
                if (seen_q < (CW+1)'(GROUP_N)) seen_q <= seen_q + (CW+1)'(1);
            end
        end
    end

    p_vld_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sum_vld == exp_vld_q);
    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sum_vld |=> !sum_vld);
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sum_vld |-> (sum_o <= SUM_MAX));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sum_vld |-> $stable(sum_o));
    p_needs_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sum_vld |-> $past(smp_en));
    p_full_group_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sum_vld |-> (seen_q >= (CW+1)'(GROUP_N)));

endmodule

bind tri_sample_summer tsum_checker #(
    .SAMPLE_W(SAMPLE_W), .GROUP_N(GROUP_N), .SUM_W(SUM_W)
) u_tsum_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_en  (smp_en),
    .sum_o   (sum_o),
    .sum_vld (sum_vld)
);

// File: tb/tri_sample_summer_bench.sv
module tri_sample_summer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_en = 1'b0;
    logic [9:0]  smp_data = '0;
    logic [11:0] sum_o;
    logic        sum_vld;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state
    int m_cnt = 0;
    int m_h0 = 0;
    int m_h1 = 0;
    int m_sum = 0;
    int m_vld = 0;

    always #4 clk = ~clk;

    tri_sample_summer u_tri_sample_summer (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_en   (smp_en),
        .smp_data (smp_data),
        .sum_o    (sum_o),
        .sum_vld  (sum_vld)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_outs(input string tag);
        chk(int'(sum_vld) == m_vld, {tag, " valid"}, int'(sum_vld), m_vld);
        chk(int'(sum_o) == m_sum, {tag, " sum"}, int'(sum_o), m_sum);
    endtask

    // Called at a falling edge: drive, pass one rising edge, check at the next falling edge.
    task automatic step(input bit en, input int d, input string tag);
        smp_en   = en;
        smp_data = 10'(d);
        if (en) begin
            if (m_cnt == 2) begin
                m_sum = m_h0 + m_h1 + d;
                m_vld = 1;
                m_cnt = 0;
            end else begin
                m_h1 = m_h0;
                m_h0 = d;
                m_vld = 0;
                m_cnt++;
            end
        end else begin
            m_vld = 0;
        end
        @(negedge clk);
        check_outs(tag);
    endtask

    task automatic do_reset(input string tag);
        smp_en = 1'b0;
        rst_n  = 1'b0;
        m_cnt = 0; m_h0 = 0; m_h1 = 0; m_sum = 0; m_vld = 0;
        @(negedge clk);
        @(negedge clk);
        check_outs(tag);
        rst_n = 1'b1;
        @(negedge clk);
        check_outs(tag);
    endtask

    initial begin
        @(negedge clk);
        // R6: outputs cleared by reset
        do_reset("R6");

        // R5: first two samples give no total, the third does
        step(1, 100, "R5");
        step(1, 200, "R5");
        step(1, 300, "R5");
        step(0, 0, "R4");

        // R1 and R9: idle cycles with large data inside a group
        step(1, 5, "R9");
        step(0, 1023, "R1");
        step(0, 777, "R1");
        step(1, 6, "R9");
        step(0, 512, "R1");
        step(1, 7, "R9");
        step(0, 1000, "R1");

        // R2: sweep all sample values, gaps every fifth sample
        for (int i = 0; i < 1024; i++) begin
            step(1, i, "R2");
            if (i % 5 == 4) step(0, 1023 - i, "R9");
        end

        // R3: full-scale samples
        do_reset("R6");
        step(1, 1023, "R3");
        step(1, 1023, "R3");
        step(1, 1023, "R3");
        step(1, 1023, "R3");
        step(1, 1022, "R3");
        step(1, 1023, "R3");

        // R7: total held across a long idle stretch
        for (int i = 0; i < 20; i++) step(0, i * 37, "R7");

        // R4: back-to-back enables produce one pulse every third cycle
        for (int i = 0; i < 30; i++) step(1, (i * 91) % 1024, "R4");

        // R8: reset with a group half filled
        step(1, 900, "R8");
        step(1, 901, "R8");
        do_reset("R8");
        step(1, 1, "R8");
        step(1, 2, "R8");
        step(1, 3, "R8");
        step(0, 0, "R8");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule